// File: doc/BRIEF.md
# Memory Region Attribute Checker

This block sorts each physical memory access into one of a set of programmable address windows before the access goes onto the internal bus. There are up to twenty windows, and each has its own permissions. A window is described by a page-aligned base, a power-of-two size and a valid bit. It also has four separate switches: reads allowed, writes allowed, cacheable, and steer-to-PCI. Descriptors are loaded one whole window at a time through a write-only configuration port.

For every access (address plus read/write flag), the block reports one clock later:
- whether any window matched, and which one;
- whether the access is allowed, and whether it may pass on;
- whether the access is cacheable;
- whether the access must be routed to PCI.

A read to a read-blocked window, or a write to a write-blocked window, is held back and marked with a single-cycle violation flag. When windows overlap, the lowest-numbered one decides. An address outside every window gets permissive default attributes.

Top module: `mem_region_guard`

## Requirements
- R1: After synchronous reset, every window is invalid and all result outputs (res_valid, res_hit, res_region, res_allow, res_cache, res_pci, res_pass, res_violation) are 0.
- R2: The result of an access presented with acc_valid=1 appears on the outputs one clock after it is sampled, with res_valid=1. A cycle with acc_valid=0 yields res_valid=0 on the next cycle.
- R3: A valid window with page number cfg_base (address bits 31:12) and size code s covers the 2^s pages whose address bits 31:(12+s) equal those of the base. A size code above 20 covers the whole address space.
- R4: When several valid windows cover an address, res_region reports the lowest-numbered one and its attributes apply.
- R5: An access that matches no window gives res_hit=0, res_region=0, res_allow=1, res_cache=1, res_pci=0.
- R6: A read (acc_write=0) to a window whose read switch is 0 gives res_allow=0, res_pass=0 and res_violation=1. A read to a window whose read switch is 1 gives res_allow=1 and res_pass=1.
- R7: A write (acc_write=1) to a window whose write switch is 0 gives res_allow=0, res_pass=0 and res_violation=1. A write to a window whose write switch is 1 passes.
- R8: res_cache and res_pci of a matched access equal the matched window's cacheable and steer-to-PCI switches.
- R9: res_violation is high only in a cycle with res_valid=1 and res_pass=0. It is a single-cycle pulse unless the next access also violates.
- R10: A descriptor write in the same cycle as an access does not change that access's result. It applies from the next access on. A write with cfg_idx of 20 or more changes nothing.
- R11: A window loaded with cfg_valid=0 never matches, so lower-priority windows or the defaults apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load descriptor cfg_idx this cycle |
| cfg_idx | input | 5 | Window number to load |
| cfg_base | input | 20 | Base page number (address bits 31:12) |
| cfg_size | input | 5 | Size code: window spans 2^code pages |
| cfg_valid | input | 1 | Window enabled |
| cfg_rd_en | input | 1 | Reads allowed |
| cfg_wr_en | input | 1 | Writes allowed |
| cfg_cache | input | 1 | Accesses are cacheable |
| cfg_pci | input | 1 | Accesses steer to PCI |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Physical address |
| acc_write | input | 1 | 1 = write, 0 = read |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Some window matched |
| res_region | output | 5 | Matched window number |
| res_allow | output | 1 | Access permitted |
| res_cache | output | 1 | Cacheable |
| res_pci | output | 1 | Route to PCI |
| res_pass | output | 1 | Access forwarded |
| res_violation | output | 1 | Access blocked by permission |

## Verification
Every result output is due exactly one clock edge after the edge that samples the access. A descriptor load is visible to an access sampled on the edge after the load edge, not on the load edge itself. The bench changes inputs on the falling edge, lets one rising edge capture them, and reads all outputs at the next falling edge. This is the middle of the one cycle in which that access's result is held. For the same-cycle load case, the bench presents the access and the load on the same falling edge. It expects the old classification first and the new one on the following access.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

  localparam int PAGE_SHIFT = 12;

  typedef struct packed {
    logic valid;
    logic rd_en;
    logic wr_en;
    logic cache;
    logic pci;
  } mrg_attr_t;

endpackage

// File: rtl/mrg_desc_bank.sv
module mrg_desc_bank
  import mrg_pkg::*;
#(
  parameter int NUM_REGIONS = 20,
  parameter int PAGE_W      = 20,
  parameter int SZ_W        = 5,
  parameter int IDX_W       = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we,
  input  logic [IDX_W-1:0]                   cfg_idx,
  input  logic [PAGE_W-1:0]                  cfg_base,
  input  logic [SZ_W-1:0]                    cfg_size,
  input  mrg_attr_t                          cfg_attr,
  output logic [NUM_REGIONS-1:0][PAGE_W-1:0] base_q,
  output logic [NUM_REGIONS-1:0][SZ_W-1:0]   size_q,
  output mrg_attr_t [NUM_REGIONS-1:0]        attr_q
);

  // Registers rather than RAM: every window is compared in parallel.
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_desc
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        size_q[g] <= '0;
        attr_q[g] <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
        base_q[g] <= cfg_base;
        size_q[g] <= cfg_size;
        attr_q[g] <= cfg_attr;
      end
    end
  end

endmodule

// File: rtl/mrg_region_match.sv
module mrg_region_match #(
  parameter int PAGE_W = 20,
  parameter int SZ_W   = 5
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] base,
  input  logic [SZ_W-1:0]   size,
  input  logic              valid,
  output logic              hit
);

  logic [PAGE_W-1:0] keep;
  logic [SZ_W:0]     eff;

  always_comb begin
    // Size codes beyond the page width cover the whole space.
    eff = ({1'b0, size} > (SZ_W+1)'(PAGE_W)) ? (SZ_W+1)'(PAGE_W) : {1'b0, size};
    for (int i = 0; i < PAGE_W; i++) begin
      keep[i] = ((SZ_W+1)'(i) >= eff);
    end
    hit = valid && (((page ^ base) & keep) == '0);
  end

endmodule

// File: rtl/mrg_select.sv
module mrg_select
  import mrg_pkg::*;
#(
  parameter int NUM_REGIONS = 20,
  parameter int IDX_W       = 5
) (
  input  logic [NUM_REGIONS-1:0]      hits,
  input  mrg_attr_t [NUM_REGIONS-1:0] attrs,
  input  logic                        is_write,
  output logic                        found,
  output logic [IDX_W-1:0]            idx,
  output logic                        allow,
  output logic                        cache,
  output logic                        pci
);

  mrg_attr_t sel;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    sel   = '0;
    // Walk downward so the lowest-numbered hit is the last to land.
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        sel   = attrs[i];
      end
    end
    if (found) begin
      allow = is_write ? sel.wr_en : sel.rd_en;
      cache = sel.cache;
      pci   = sel.pci;
    end else begin
      allow = 1'b1;
      cache = 1'b1;
      pci   = 1'b0;
    end
  end

endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
  import mrg_pkg::*;
#(
  parameter int NUM_REGIONS = 20,
  parameter int ADDR_W      = 32,
  parameter int PAGE_W      = ADDR_W - PAGE_SHIFT,
  parameter int SZ_W        = $clog2(PAGE_W + 1),
  parameter int IDX_W       = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [PAGE_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic              cfg_valid,
  input  logic              cfg_rd_en,
  input  logic              cfg_wr_en,
  input  logic              cfg_cache,
  input  logic              cfg_pci,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_region,
  output logic              res_allow,
  output logic              res_cache,
  output logic              res_pci,
  output logic              res_pass,
  output logic              res_violation
);

  logic [NUM_REGIONS-1:0][PAGE_W-1:0] base_q;
  logic [NUM_REGIONS-1:0][SZ_W-1:0]   size_q;
  mrg_attr_t [NUM_REGIONS-1:0]        attr_q;
  mrg_attr_t                          cfg_attr;
  logic [NUM_REGIONS-1:0]             hits;
  logic [PAGE_W-1:0]                  page;
  logic                               found, allow, cache, pci;
  logic [IDX_W-1:0]                   idx;

  assign cfg_attr = '{valid: cfg_valid, rd_en: cfg_rd_en, wr_en: cfg_wr_en,
                      cache: cfg_cache, pci: cfg_pci};
  assign page = acc_addr[ADDR_W-1:PAGE_SHIFT];

  mrg_desc_bank #(
    .NUM_REGIONS(NUM_REGIONS), .PAGE_W(PAGE_W), .SZ_W(SZ_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_attr(cfg_attr),
    .base_q(base_q), .size_q(size_q), .attr_q(attr_q)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    mrg_region_match #(.PAGE_W(PAGE_W), .SZ_W(SZ_W)) u_match (
      .page(page), .base(base_q[g]), .size(size_q[g]),
      .valid(attr_q[g].valid), .hit(hits[g])
    );
  end

  mrg_select #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_sel (
    .hits(hits), .attrs(attr_q), .is_write(acc_write),
    .found(found), .idx(idx), .allow(allow), .cache(cache), .pci(pci)
  );

  always_ff @(posedge clk) begin
    if (rst || !acc_valid) begin
      res_valid     <= 1'b0;
      res_hit       <= 1'b0;
      res_region    <= '0;
      res_allow     <= 1'b0;
      res_cache     <= 1'b0;
      res_pci       <= 1'b0;
      res_pass      <= 1'b0;
      res_violation <= 1'b0;
    end else begin
      res_valid     <= 1'b1;
      res_hit       <= found;
      res_region    <= idx;
      res_allow     <= allow;
      res_cache     <= cache;
      res_pci       <= pci;
      res_pass      <= allow;
      res_violation <= !allow;
    end
  end

endmodule

// File: rtl/mrg_checker.sv
module mrg_checker #(
  parameter int NUM_REGIONS = 20,
  parameter int IDX_W       = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             res_valid,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_region,
  input logic             res_allow,
  input logic             res_cache,
  input logic             res_pci,
  input logic             res_pass,
  input logic             res_violation
);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !res_valid);

  p_default_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_allow && res_cache && !res_pci && res_region == '0));

  p_index_range_r4: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (int'(res_region) < NUM_REGIONS));

  p_violation_r9: assert property (@(posedge clk) disable iff (rst)
    res_violation |-> (res_valid && !res_pass && !res_allow));

  p_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_allow) |-> (res_pass && !res_violation));

  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_pass && !res_violation && !res_hit));

endmodule

bind mem_region_guard mrg_checker #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .res_valid(res_valid),
  .res_hit(res_hit), .res_region(res_region), .res_allow(res_allow),
  .res_cache(res_cache), .res_pci(res_pci), .res_pass(res_pass),
  .res_violation(res_violation)
);

// File: tb/mem_region_guard_bench.sv
`timescale 1ns/1ps
module mem_region_guard_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [19:0] cfg_base = '0;
  logic [4:0]  cfg_size = '0;
  logic        cfg_valid = 1'b0, cfg_rd_en = 1'b0, cfg_wr_en = 1'b0;
  logic        cfg_cache = 1'b0, cfg_pci = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        res_valid, res_hit, res_allow, res_cache, res_pci, res_pass, res_violation;
  logic [4:0]  res_region;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mem_region_guard u_mem_region_guard (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_valid(cfg_valid), .cfg_rd_en(cfg_rd_en),
    .cfg_wr_en(cfg_wr_en), .cfg_cache(cfg_cache), .cfg_pci(cfg_pci),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .res_valid(res_valid), .res_hit(res_hit), .res_region(res_region),
    .res_allow(res_allow), .res_cache(res_cache), .res_pci(res_pci),
    .res_pass(res_pass), .res_violation(res_violation)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected result vector: hit, region, allow, cache, pci
  task automatic chk_res(string req, logic hit, logic [4:0] reg_n, logic allow,
                         logic cache, logic pci);
    chk(req, "valid", res_valid, 1);
    chk(req, "hit", res_hit, hit);
    chk(req, "region", res_region, reg_n);
    chk(req, "allow", res_allow, allow);
    chk(req, "cache", res_cache, cache);
    chk(req, "pci", res_pci, pci);
    chk(req, "pass", res_pass, allow);
    chk(req, "violation", res_violation, !allow);
  endtask

  task automatic load(logic [4:0] idx, logic [19:0] base, logic [4:0] sz,
                      logic v, logic rd, logic wr, logic c, logic p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_size = sz;
    cfg_valid = v; cfg_rd_en = rd; cfg_wr_en = wr; cfg_cache = c; cfg_pci = p;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Present one access; return at the falling edge where its result is held.
  task automatic access(logic [31:0] addr, logic wr);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = addr; acc_write = wr;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "valid", res_valid, 0);
    chk("R1", "hit", res_hit, 0);
    chk("R1", "pass", res_pass, 0);
    chk("R1", "violation", res_violation, 0);
    access(32'h0001_2345, 1'b0);
    chk_res("R1", 0, 0, 1, 1, 0);
  endtask

  task automatic t_default;
    access(32'hABCD_0000, 1'b1);
    chk_res("R5", 0, 0, 1, 1, 0);
  endtask

  task automatic t_match_perm;
    // window 0: 64 KB at 0x10000, read only, uncached, PCI
    load(5'd0, 20'h00010, 5'd4, 1, 1, 0, 0, 1);
    access(32'h0001_2345, 1'b0);
    chk_res("R3 R6 R8", 1, 0, 1, 0, 1);
    access(32'h0001_FFFC, 1'b1);
    chk_res("R7", 1, 0, 0, 0, 1);
    @(negedge clk);
    chk("R9", "violation pulse end", res_violation, 0);
    chk("R2", "idle valid", res_valid, 0);
    access(32'h0002_0000, 1'b0);
    chk_res("R3 edge", 0, 0, 1, 1, 0);
    access(32'h0000_F000, 1'b0);
    chk_res("R3 edge low", 0, 0, 1, 1, 0);
  endtask

  task automatic t_priority;
    // window 3: 1 MB at 0, all allowed, cacheable
    load(5'd3, 20'h00000, 5'd8, 1, 1, 1, 1, 0);
    access(32'h0001_2345, 1'b0);
    chk_res("R4", 1, 0, 1, 0, 1);
    access(32'h0003_0000, 1'b1);
    chk_res("R4 R7", 1, 3, 1, 1, 0);
  endtask

  task automatic t_invalid;
    load(5'd0, 20'h00010, 5'd4, 0, 0, 0, 0, 1);
    access(32'h0001_2345, 1'b0);
    chk_res("R11", 1, 3, 1, 1, 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'd1; cfg_base = 20'h00040; cfg_size = 5'd0;
    cfg_valid = 1; cfg_rd_en = 0; cfg_wr_en = 1; cfg_cache = 0; cfg_pci = 1;
    acc_valid = 1'b1; acc_addr = 32'h0004_0010; acc_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    acc_valid = 1'b1;
    chk_res("R10 old", 1, 3, 1, 1, 0);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    chk_res("R10 new", 1, 1, 0, 0, 1);
    @(negedge clk);
    chk("R9", "no violation when idle", res_violation, 0);
  endtask

  task automatic t_bad_index;
    load(5'd25, 20'hF0000, 5'd31, 1, 0, 0, 0, 1);
    access(32'hF000_1000, 1'b0);
    chk_res("R10 index", 0, 0, 1, 1, 0);
  endtask

  task automatic t_clamp;
    load(5'd19, 20'h12345, 5'd31, 1, 1, 0, 0, 1);
    access(32'hF000_1000, 1'b0);
    chk_res("R3 clamp", 1, 19, 1, 0, 1);
    access(32'hF000_1000, 1'b1);
    chk_res("R3 R7 clamp", 1, 19, 0, 0, 1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_default();
    t_match_perm();
    t_priority();
    t_invalid();
    t_same_cycle();
    t_bad_index();
    t_clamp();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule